// File: doc/BRIEF.md
# Scrambled March C- Memory Self-Test Controller

This controller checks a word-addressed single-port SRAM with a six-pass March C- walk. A pulse on `start_i` begins a run. The controller owns the memory's address, write-data, write-enable and read-enable lines and compares each returned word against the value it expects. When the run ends it raises `done_o` for one cycle. `pass_o` then holds the overall result. `fail_addr_o` and `fail_exp_o` identify the first location that miscompared.

The four read-modify passes do not step through memory linearly. They cover the array one block at a time and pick the visiting order inside a block from a parameter table of physical offsets. Rising passes take each offset from a forward table and add it to the block base. Falling passes start at the top word, step down by one block, and subtract each offset taken from a separate reversed table. The first pass and the last pass ignore scrambling and step linearly.

The memory returns read data one cycle after the read. For each location of a read pass the controller reads in one cycle, then compares and writes in the next. Errors are recorded and kept, and the run always finishes.

Top module: `march_bist`

## Requirements
- R1: A run performs six passes in this fixed order: rising write of zeros; rising read-zeros/write-ones; rising read-ones/write-zeros; falling read-zeros/write-ones; falling read-ones/write-zeros; rising read-zeros.
- R2: The background word is all zeros and its inverse is all ones over the full data width. Every write carries one of these two values.
- R3: In passes 2 and 3, location number k goes to address (k/BLK)*BLK + FWD[k mod BLK]. The default table for BLK=4 is 0,1,3,2, with entry j packed at bits [2j+1:2j]. A table that is not a permutation of 0..BLK-1 is flagged at elaboration.
- R4: In passes 4 and 5, location number k goes to address (WORDS-1) - (k/BLK)*BLK - REV[k mod BLK]. The default reversed table is 0,1,3,2.
- R5: Passes 1 and 6 visit addresses 0 to WORDS-1 linearly. Pass 1 issues one write per cycle.
- R6: In the read passes, each location takes two cycles. The first cycle is a read with read-enable high. In the next cycle the address is unchanged, the returned data is compared, and the write to that same address follows (passes 2 to 5 only). Read-enable and write-enable are never both high.
- R7: A miscompare clears `pass_o`, and `pass_o` stays low for the rest of the run. The run still finishes all six passes, with every access issued.
- R8: `fail_addr_o` and `fail_exp_o` capture the address and expected word of the first miscompare of a run. They hold those values after the run ends, until the next start.
- R9: A `start_i` pulse while `busy_o` is high has no effect on the access sequence.
- R10: `done_o` is high for exactly one cycle, in the first cycle in which `busy_o` is low. An accepted start clears `pass_o` back to 1 and `fail_addr_o`/`fail_exp_o` to 0.
- R11: After reset, `busy_o`, `done_o`, `mem_we_o`, `mem_re_o` and `fail_addr_o` are 0 and `pass_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; ignored while busy |
| mem_addr_o | output | $clog2(WORDS) | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable; data returns next cycle |
| mem_rdata_i | input | DATA_W | Memory read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | High while no miscompare seen since the last start |
| fail_addr_o | output | $clog2(WORDS) | Address of the first miscompare |
| fail_exp_o | output | DATA_W | Expected word at the first miscompare |

## Verification
The hardest behaviour to provoke from the ports is a first failure whose address depends on the scramble order. Two faulty neighbours must sit in the same block, so that only the table's visiting order decides which one is recorded. The bench's memory model injects stuck-at-1 bits at words 6 and 7. With the default table 7 is visited before 6, so 7 must be recorded. A stuck-at-0 bit near the top of the array is only seen once ones have been written. A further run combines an early and a late fault, to show that the first capture is held while later errors keep the run failing to the end.

// File: rtl/march_pkg.sv
`timescale 1ns/1ps
package march_pkg;

  typedef enum logic [2:0] {
    E_WR_BG   = 3'd0,
    E_UP_R0W1 = 3'd1,
    E_UP_R1W0 = 3'd2,
    E_DN_R0W1 = 3'd3,
    E_DN_R1W0 = 3'd4,
    E_UP_R0   = 3'd5
  } elem_e;

  function automatic logic elem_reads(elem_e e);
    return e != E_WR_BG;
  endfunction

  function automatic logic elem_rmw(elem_e e);
    return e != E_WR_BG && e != E_UP_R0;
  endfunction

  function automatic logic elem_scr(elem_e e);
    return elem_rmw(e);
  endfunction

  function automatic logic elem_desc(elem_e e);
    return e == E_DN_R0W1 || e == E_DN_R1W0;
  endfunction

  function automatic logic elem_exp_ones(elem_e e);
    return e == E_UP_R1W0 || e == E_DN_R1W0;
  endfunction

  function automatic logic elem_wr_ones(elem_e e);
    return e == E_UP_R0W1 || e == E_DN_R0W1;
  endfunction

endpackage

// File: rtl/march_seq.sv
`timescale 1ns/1ps
module march_seq
  import march_pkg::*;
#(
  parameter int unsigned WORDS = 2048,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          clr_o,
  output elem_e         elem_o,
  output logic [IW-1:0] idx_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          chk_o
);

  logic          busy_q, done_q, ph_q;
  elem_e         elem_q;
  logic [IW-1:0] idx_q;
  logic          step, last;

  assign last  = idx_q == IW'(WORDS - 1);
  assign step  = busy_q && (elem_q == E_WR_BG || ph_q);
  assign clr_o = !busy_q && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ph_q   <= 1'b0;
      elem_q <= E_WR_BG;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          elem_q <= E_WR_BG;
          idx_q  <= '0;
          ph_q   <= 1'b0;
        end
      end else if (step) begin
        ph_q <= 1'b0;
        if (last) begin
          if (elem_q == E_UP_R0) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            elem_q <= elem_e'(elem_q + 3'd1);
            idx_q  <= '0;
          end
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else begin
        ph_q <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign elem_o = elem_q;
  assign idx_o  = idx_q;
  assign rd_o   = busy_q && elem_reads(elem_q) && !ph_q;
  assign wr_o   = busy_q && (elem_q == E_WR_BG || (elem_rmw(elem_q) && ph_q));
  assign chk_o  = busy_q && elem_reads(elem_q) && ph_q;

  // R9: start while busy leaves position alone unless the walk steps anyway
  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i && !step |=> busy_q && $stable(idx_q) && $stable(elem_q));

  // R1: passes advance strictly in order
  a_r1_elem_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && last && elem_q != E_UP_R0 |=> elem_q == elem_e'($past(elem_q) + 3'd1) && idx_q == '0);

endmodule

// File: rtl/march_addr_gen.sv
`timescale 1ns/1ps
module march_addr_gen
  import march_pkg::*;
#(
  parameter int unsigned WORDS = 2048,
  parameter int unsigned BLK   = 4,
  localparam int unsigned AW   = $clog2(WORDS),
  localparam int unsigned OW   = $clog2(BLK),
  parameter logic [BLK*OW-1:0] FWD_TBL = 8'hB4,
  parameter logic [BLK*OW-1:0] REV_TBL = 8'hB4
) (
  input  elem_e         elem_i,
  input  logic [AW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);

  logic [OW-1:0] fwd_off [BLK];
  logic [OW-1:0] rev_off [BLK];

  for (genvar g = 0; g < BLK; g++) begin : g_tbl
    assign fwd_off[g] = FWD_TBL[g*OW +: OW];
    assign rev_off[g] = REV_TBL[g*OW +: OW];
  end

  logic [OW-1:0] off;
  logic [AW-1:0] base, f_ext, r_ext;

  assign off   = idx_i[OW-1:0];
  assign base  = {idx_i[AW-1:OW], {OW{1'b0}}};
  assign f_ext = {{(AW-OW){1'b0}}, fwd_off[off]};
  assign r_ext = {{(AW-OW){1'b0}}, rev_off[off]};

  always_comb begin
    if (!elem_scr(elem_i))      addr_o = idx_i;
    else if (elem_desc(elem_i)) addr_o = AW'(WORDS - 1) - base - r_ext;
    else                        addr_o = base + f_ext;
  end

  // R3, R4: tables must be permutations; region and block powers of two
  initial begin
    a_r3_geometry: assert (WORDS == (1 << AW) && BLK == (1 << OW) && BLK >= 2 && WORDS >= BLK)
      else $error("geometry must be powers of two");
    for (int v = 0; v < BLK; v++) begin
      int nf, nr;
      nf = 0;
      nr = 0;
      for (int j = 0; j < BLK; j++) begin
        if (int'(FWD_TBL[j*OW +: OW]) == v) nf++;
        if (int'(REV_TBL[j*OW +: OW]) == v) nr++;
      end
      a_r3_fwd_perm: assert (nf == 1) else $error("forward table not a permutation");
      a_r4_rev_perm: assert (nr == 1) else $error("reversed table not a permutation");
    end
  end

endmodule

// File: rtl/march_cmp.sv
`timescale 1ns/1ps
module march_cmp #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              chk_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              err_o,
  output logic [AW-1:0]     fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o
);

  logic              err_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] exp_q;
  logic              miss;

  assign miss = chk_i && (rdata_i != exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      addr_q <= '0;
      exp_q  <= '0;
    end else if (clr_i) begin
      err_q  <= 1'b0;
      addr_q <= '0;
      exp_q  <= '0;
    end else if (miss && !err_q) begin
      err_q  <= 1'b1;
      addr_q <= addr_i;
      exp_q  <= exp_i;
    end
  end

  assign err_o       = err_q;
  assign fail_addr_o = addr_q;
  assign fail_exp_o  = exp_q;

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !clr_i |=> err_q);

  a_r8_first_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !clr_i |=> $stable(addr_q) && $stable(exp_q));

  // R7: a miscompare is never lost
  a_r7_miss_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_i && !clr_i && (rdata_i != exp_i) |=> err_q);

endmodule

// File: rtl/march_bist.sv
`timescale 1ns/1ps
module march_bist
  import march_pkg::*;
#(
  parameter int unsigned WORDS  = 2048,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BLK    = 4,
  localparam int unsigned AW    = $clog2(WORDS),
  localparam int unsigned OW    = $clog2(BLK),
  parameter logic [BLK*OW-1:0] FWD_TBL = 8'hB4,
  parameter logic [BLK*OW-1:0] REV_TBL = 8'hB4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [AW-1:0]     fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o
);

  elem_e         elem;
  logic [AW-1:0] idx;
  logic          clr, rd, wr, chk, err;
  logic [DATA_W-1:0] exp_word;

  march_seq #(.WORDS(WORDS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .clr_o   (clr),
    .elem_o  (elem),
    .idx_o   (idx),
    .rd_o    (rd),
    .wr_o    (wr),
    .chk_o   (chk)
  );

  march_addr_gen #(
    .WORDS   (WORDS),
    .BLK     (BLK),
    .FWD_TBL (FWD_TBL),
    .REV_TBL (REV_TBL)
  ) u_addr (
    .elem_i (elem),
    .idx_i  (idx),
    .addr_o (mem_addr_o)
  );

  assign exp_word    = elem_exp_ones(elem) ? '1 : '0;
  assign mem_wdata_o = elem_wr_ones(elem)  ? '1 : '0;
  assign mem_we_o    = wr;
  assign mem_re_o    = rd;

  march_cmp #(.DATA_W(DATA_W), .AW(AW)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .chk_i       (chk),
    .addr_i      (mem_addr_o),
    .exp_i       (exp_word),
    .rdata_i     (mem_rdata_i),
    .err_o       (err),
    .fail_addr_o (fail_addr_o),
    .fail_exp_o  (fail_exp_o)
  );

  assign pass_o = !err;

  a_r6_single_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  a_r6_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> $stable(mem_addr_o) && !mem_re_o);

  a_r6_rmw_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o && elem_rmw(elem) |=> mem_we_o);

  a_r2_wdata_values: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == '0 || mem_wdata_o == '1));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

endmodule

// File: tb/test_march_bist.sv
`timescale 1ns/1ps
module test_march_bist;
  localparam int WORDS = 2048;
  localparam int DW    = 32;
  localparam int AW    = 11;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] addr, fail_addr;
  logic [DW-1:0] wdata, rdata = '0, fail_exp;
  logic we, re, busy, done, pass;

  march_bist i_march_bist (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we), .mem_re_o(re),
    .mem_rdata_i(rdata), .busy_o(busy), .done_o(done), .pass_o(pass),
    .fail_addr_o(fail_addr), .fail_exp_o(fail_exp)
  );

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] sa1 [WORDS];
  logic [DW-1:0] sa0 [WORDS];

  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= (mem[addr] | sa1[addr]) & ~sa0[addr];
  end

  typedef struct { bit w; int a; logic [DW-1:0] d; string tag; } op_t;
  op_t q[$];
  int checks = 0, errors = 0, done_cnt = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void push(bit w, int a, logic [DW-1:0] d, string tag);
    op_t o;
    o.w = w; o.a = a; o.d = d; o.tag = tag;
    q.push_back(o);
  endfunction

  task automatic build_seq();
    int tbl [4] = '{0, 1, 3, 2};
    q.delete();
    for (int a = 0; a < WORDS; a++) push(1, a, '0, "R1 R5");
    for (int e = 1; e <= 4; e++)
      for (int b = 0; b < WORDS / 4; b++)
        for (int j = 0; j < 4; j++) begin
          int a;
          if (e <= 2) a = b * 4 + tbl[j];
          else        a = WORDS - 1 - b * 4 - tbl[j];
          push(0, a, '0, e <= 2 ? "R3 R6" : "R4 R6");
          push(1, a, (e == 1 || e == 3) ? '1 : '0, "R2 R6");
        end
    for (int a = 0; a < WORDS; a++) push(0, a, '0, "R1 R5");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (we || re) begin
        if (q.size() == 0) begin
          check(0, "R7", "unexpected access", {we, re}, 0);
        end else begin
          op_t o;
          o = q.pop_front();
          check(we == o.w && re == !o.w, o.tag, "op kind", {we, re}, {o.w, !o.w});
          check(int'(addr) == o.a, o.tag, "address", addr, o.a);
          if (o.w) check(wdata == o.d, o.tag, "write data", wdata, o.d);
        end
      end
    end
  end

  task automatic clear_faults();
    for (int a = 0; a < WORDS; a++) begin sa1[a] = '0; sa0[a] = '0; end
  endtask

  task automatic run(bit restart, bit exp_pass, int exp_addr, logic [DW-1:0] exp_word);
    int cyc = 0;
    int d0;
    build_seq();
    d0 = done_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check(busy == 1 && pass == 1, "R10", "cleared on start", {busy, pass}, 2'b11);
    check(fail_addr == 0, "R10", "fail addr cleared", fail_addr, 0);
    while (!done && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      start = restart && cyc == 3000;
    end
    start = 1'b0;
    check(done == 1 && busy == 0, "R10", "done with busy low", {done, busy}, 2'b10);
    check(q.size() == 0, "R7", "all accesses issued", q.size(), 0);
    check(pass == exp_pass, "R7", "pass flag", pass, exp_pass);
    if (!exp_pass) begin
      check(int'(fail_addr) == exp_addr, "R8", "first fail addr", fail_addr, exp_addr);
      check(fail_exp == exp_word, "R8", "first fail expected", fail_exp, exp_word);
    end
    @(negedge clk);
    check(done == 0, "R10", "done one cycle", done, 0);
    check(done_cnt == d0 + 1, restart ? "R9" : "R10", "done count", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_faults();
    for (int a = 0; a < WORDS; a++) mem[a] = 32'h5a5a_5a5a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(busy == 0 && done == 0, "R11", "busy/done", {busy, done}, 0);
    check(we == 0 && re == 0, "R11", "mem enables", {we, re}, 0);
    check(pass == 1 && fail_addr == 0, "R11", "pass/fail addr", {pass, fail_addr}, {1'b1, 11'd0});

    // clean memory with a stray start mid-run (R9)
    run(1, 1, 0, '0);

    // stuck-at-1 in words 6 and 7: scramble visits 7 first (R3, R8)
    sa1[6] = 32'h1; sa1[7] = 32'h1;
    run(0, 0, 7, '0);
    repeat (20) @(negedge clk);
    check(int'(fail_addr) == 7 && pass == 0, "R8", "result held after run", fail_addr, 7);

    // stuck-at-0 near top, seen only once ones are expected
    clear_faults();
    sa0[2045] = 32'h8000_0000;
    run(0, 0, 2045, '1);

    // early and late faults: first capture kept, run still completes (R7)
    clear_faults();
    sa1[1000] = 32'h20;
    sa0[10]   = 32'h8;
    run(0, 0, 1000, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule